// File: doc/BRIEF.md
# Bus Slave Timing Sequencer

This block sits between a simple on-chip master port and one slow peripheral that needs set-up, strobe-width and hold margins on its control lines. When the master raises a read or write request, the block drives chipselect, address and byte enables to the peripheral. It then runs three phases, each counted in clocks. First comes a set-up phase with no strobe. Next is a strobe phase in which the active-low read or write strobe is low. Last, for writes only, comes a hold phase in which the strobe is back high but address, byte enables and write data are still driven.

Waitrequest stays high toward the master until the last cycle of the sequence. The master keeps its request and signals unchanged while waitrequest is high. Read data is passed through to the master in the last strobe cycle and is also registered then, so it stays visible after completion. The three phase lengths are compile-time parameters. With all three set to zero, each transfer finishes in the clock in which it is requested.

Top module: `bus_seq_timer`

## Requirements
- R1: While reset is low, chipselect is low, both strobes are high and all active-low byte enables are high, even if a request is present.
- R2: Chipselect and address appear in the first cycle of a transfer. The strobe goes low exactly SETUP cycles later, and chipselect never goes low while a strobe is low.
- R3: The read or write strobe stays low for exactly 1+WAIT consecutive cycles of a transfer.
- R4: After the write strobe rises, chipselect, address, byte enables (active-low, bit i = NOT master byte enable bit i) and write data stay driven for HOLD more cycles. The write then completes.
- R5: A read has no hold phase. Its last cycle is the last strobe cycle, and chipselect is low in the next cycle unless a new request is present.
- R6: Waitrequest is high during every cycle of a requested transfer except the last. A read lasts SETUP+1+WAIT cycles and a write lasts SETUP+1+WAIT+HOLD cycles. Address holds steady while waitrequest is high.
- R7: In a read's completing cycle, master read data equals the slave read data of that cycle. It keeps that value afterwards until the next read completes.
- R8: With SETUP=WAIT=HOLD=0, a read or a write asserts its strobe and completes (waitrequest low) in its first cycle.
- R9: While chipselect is high, the slave byte enables are the bitwise inverse of the master byte enables.
- R10: If read and write are requested together, a write is performed. The read strobe never goes low, and the two strobes are never low at the same time.
- R11: A request that is present in the cycle after a completion starts a new full-length sequence, beginning again with its set-up phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_addr | input | ADDR_W | Master address |
| m_be | input | DATA_W/8 | Master byte enables, active high |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | DATA_W | Master write data |
| m_rdata | output | DATA_W | Read data returned to master |
| m_waitreq | output | 1 | High while the requested transfer is not yet complete |
| s_cs | output | 1 | Slave chipselect, active high |
| s_rd_n | output | 1 | Slave read strobe, active low |
| s_wr_n | output | 1 | Slave write strobe, active low |
| s_be_n | output | DATA_W/8 | Slave byte enables, active low |
| s_addr | output | ADDR_W | Slave address |
| s_wdata | output | DATA_W | Slave write data |
| s_rdata | input | DATA_W | Slave read data |

## Verification
Two events can fall in the same cycle: the completion of one transfer and the set-up start of the next. When the master issues a new request in the cycle right after a completion, the counter must reload, and there is no idle cycle in which to do it. Random traffic with gaps of zero, one or two cycles provokes this case many times. In every cycle of each transfer, the bench checks the strobe level, chipselect, address and the position of the completing cycle, measured from the transfer's own first cycle. A sequence that failed to restart would show a strobe or completion in the wrong cycle. Read completion and read-data capture also share one cycle, and the bench checks the returned data both in that cycle and in the cycle after it.

// File: rtl/bus_seq_pkg.sv
// Package: shared types for the bus slave timing sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package bus_seq_pkg;

    // Phase of the current slave access
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/bus_seq_ctrl.sv
// Module: bus_seq_ctrl
// Tracks the cycle position inside a transfer. Cycle 0 is the cycle the
// request is first seen while idle (combinational start); later cycles come
// from a registered counter. Assumes the master holds its request stable
// while waitrequest is high. Write wins when both requests are present.
module bus_seq_ctrl #(
    parameter int SETUP = 2,
    parameter int WAIT  = 1,
    parameter int HOLD  = 1,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_rd,
    input  logic             req_wr,
    output logic             active,
    output logic             is_wr,
    output logic [CNT_W-1:0] pos,
    output logic             done
);
    localparam int LAST_RD = SETUP + WAIT;
    localparam int LAST_WR = SETUP + WAIT + HOLD;

    logic             busy_q;
    logic             wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start;
    logic [CNT_W-1:0] last_pos;

    // Decode start, current kind, position and completion
    always_comb begin
        start    = rst_n && !busy_q && (req_rd || req_wr);
        active   = rst_n && (busy_q || start);
        is_wr    = busy_q ? wr_q : req_wr;
        pos      = busy_q ? cnt_q : '0;
        last_pos = is_wr ? CNT_W'(LAST_WR) : CNT_W'(LAST_RD);
        done     = active && (pos == last_pos);
    end

    // Advance the position counter and remember the transfer kind
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            busy_q <= 1'b1;
            wr_q   <= is_wr;
            cnt_q  <= pos + CNT_W'(1);
        end
    end

    // R11: a completion always returns the sequencer to idle
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy_q);

    // R6: the position never runs past the longest sequence
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (int'(cnt_q) <= LAST_WR));

endmodule

// File: rtl/bus_seq_phase.sv
// Module: bus_seq_phase
// Maps the cycle position to set-up, strobe or hold phase and flags the
// last strobe cycle, where read data is taken. Assumes pos is zero when idle.
module bus_seq_phase
    import bus_seq_pkg::*;
#(
    parameter int SETUP = 2,
    parameter int WAIT  = 1,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] pos,
    output phase_e           phase,
    output logic             last_strobe
);
    localparam int STB_END = SETUP + WAIT;

    int p;

    // Classify the current position into a phase
    always_comb begin
        p = int'(pos);
        if (!active)
            phase = PH_IDLE;
        else if (p < SETUP)
            phase = PH_SETUP;
        else if (p <= STB_END)
            phase = PH_STROBE;
        else
            phase = PH_HOLD;
        last_strobe = active && (p == STB_END);
    end

    // R2: a set-up cycle is followed by set-up or strobe (request is held)
    assert_setup_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_STROBE));

endmodule

// File: rtl/bus_seq_rcap.sv
// Module: bus_seq_rcap
// Registers slave read data in the capture cycle and forwards the live value
// in that same cycle, so zero-wait reads can finish in one clock.
module bus_seq_rcap #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] s_rdata,
    output logic [DATA_W-1:0] m_rdata
);
    logic [DATA_W-1:0] rdata_q;

    // Hold the last captured read value
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (cap)
            rdata_q <= s_rdata;
    end

    // Forward live data in the capture cycle, held data otherwise
    always_comb begin
        m_rdata = cap ? s_rdata : rdata_q;
    end

endmodule

// File: rtl/bus_seq_timer.sv
// Module: bus_seq_timer (top)
// Turns a master read/write request into a chipselect + active-low strobe
// sequence with SETUP, WAIT and HOLD clocks; waitrequest covers the sequence.
// Assumes a master that holds request, address, byte enables and data while
// waitrequest is high.
module bus_seq_timer
    import bus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETUP  = 2,
    parameter int WAIT   = 1,
    parameter int HOLD   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      m_addr,
    input  logic [DATA_W/8-1:0]    m_be,
    input  logic                   m_read,
    input  logic                   m_write,
    input  logic [DATA_W-1:0]      m_wdata,
    output logic [DATA_W-1:0]      m_rdata,
    output logic                   m_waitreq,
    output logic                   s_cs,
    output logic                   s_rd_n,
    output logic                   s_wr_n,
    output logic [DATA_W/8-1:0]    s_be_n,
    output logic [ADDR_W-1:0]      s_addr,
    output logic [DATA_W-1:0]      s_wdata,
    input  logic [DATA_W-1:0]      s_rdata
);
    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = $clog2(SETUP + WAIT + HOLD + 2);

    logic             active;
    logic             is_wr;
    logic             done;
    logic [CNT_W-1:0] pos;
    phase_e           phase;
    logic             last_strobe;
    logic             strobe;

    bus_seq_ctrl #(
        .SETUP(SETUP), .WAIT(WAIT), .HOLD(HOLD), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_rd(m_read), .req_wr(m_write),
        .active(active), .is_wr(is_wr), .pos(pos), .done(done)
    );

    bus_seq_phase #(
        .SETUP(SETUP), .WAIT(WAIT), .CNT_W(CNT_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .active(active), .pos(pos),
        .phase(phase), .last_strobe(last_strobe)
    );

    bus_seq_rcap #(
        .DATA_W(DATA_W)
    ) u_rcap (
        .clk(clk), .rst_n(rst_n), .cap(last_strobe && !is_wr),
        .s_rdata(s_rdata), .m_rdata(m_rdata)
    );

    // Drive slave-side control and data from the phase and the held request
    always_comb begin
        strobe    = (phase == PH_STROBE);
        s_cs      = active;
        s_rd_n    = !(strobe && !is_wr);
        s_wr_n    = !(strobe && is_wr);
        s_addr    = active ? m_addr : '0;
        s_be_n    = active ? ~m_be : {BE_W{1'b1}};
        s_wdata   = (active && is_wr) ? m_wdata : '0;
        m_waitreq = (m_read || m_write) && !done;
    end

    // R1: reset keeps the slave side inactive
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (!s_cs && s_rd_n && s_wr_n));

    // R10: never both strobes at once
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!s_rd_n && !s_wr_n));

    // R2: a strobe only with chipselect
    assert_strobe_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_rd_n || !s_wr_n) |-> s_cs);

    // R6: address steady while the master is stalled
    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cs && m_waitreq) |=> $stable(s_addr));

endmodule

// File: tb/bus_seq_timer_bench.sv
module bus_seq_timer_bench;
    localparam int S = 2, W = 1, H = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] m_addr = '0;
    logic [3:0]  m_be = '0;
    logic        m_read = 1'b0, m_write = 1'b0;
    logic [31:0] m_wdata = '0, s_rdata = '0;
    logic [31:0] m_rdata, m_rdata_z, s_wdata, s_wdata_z;
    logic        m_waitreq, m_waitreq_z, s_cs, s_cs_z;
    logic        s_rd_n, s_rd_n_z, s_wr_n, s_wr_n_z;
    logic [3:0]  s_be_n, s_be_n_z;
    logic [15:0] s_addr, s_addr_z;

    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bus_seq_timer #(.SETUP(S), .WAIT(W), .HOLD(H)) u_bus_seq_timer (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_be(m_be),
        .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_waitreq(m_waitreq), .s_cs(s_cs),
        .s_rd_n(s_rd_n), .s_wr_n(s_wr_n), .s_be_n(s_be_n),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata));

    bus_seq_timer #(.SETUP(0), .WAIT(0), .HOLD(0)) u_bus_seq_timer_z (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_be(m_be),
        .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
        .m_rdata(m_rdata_z), .m_waitreq(m_waitreq_z), .s_cs(s_cs_z),
        .s_rd_n(s_rd_n_z), .s_wr_n(s_wr_n_z), .s_be_n(s_be_n_z),
        .s_addr(s_addr_z), .s_wdata(s_wdata_z), .s_rdata(s_rdata));

    function automatic int exp_len(bit wr);
        return wr ? (S + 1 + W + H) : (S + 1 + W);
    endfunction

    function automatic bit exp_strobe(int k);
        return (k >= S) && (k <= S + W);
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One transfer; caller is at a falling edge
    task automatic xfer(bit do_w, bit do_r, logic [15:0] a, logic [3:0] b,
                        logic [31:0] d, int gap);
        int len = exp_len(do_w);
        int k = 0;
        bit fin = 0;
        bit stb;
        logic [31:0] rd_exp = '0;
        string rq_stb;
        m_addr = a; m_be = b; m_wdata = d; m_write = do_w; m_read = do_r;
        rq_stb = (do_w && do_r) ? "R10" : "R3";
        while (!fin) begin
            #1;
            stb = exp_strobe(k);
            chk(s_cs == 1'b1, k < S ? "R2" : "R4", "cs in sequence", s_cs, 1);
            chk(s_addr == a, "R2", "address driven", s_addr, a);
            chk(s_be_n == ~b, "R9", "byte enables", s_be_n, ~b);
            if (do_w) begin
                chk(s_wr_n == !stb, k < S ? "R2" : rq_stb, "write strobe", s_wr_n, !stb);
                chk(s_rd_n == 1'b1, "R10", "read strobe idle", s_rd_n, 1);
                chk(s_wdata == d, "R4", "write data", s_wdata, d);
            end else begin
                chk(s_rd_n == !stb, k < S ? "R2" : "R3", "read strobe", s_rd_n, !stb);
                chk(s_wr_n == 1'b1, "R3", "write strobe idle", s_wr_n, 1);
            end
            if (k == 0) begin
                chk(s_cs_z && !m_waitreq_z, "R8", "zero-config completes", m_waitreq_z, 0);
                if (do_w)
                    chk(s_wr_n_z == 1'b0, "R8", "zero-config write strobe", s_wr_n_z, 0);
                else begin
                    chk(s_rd_n_z == 1'b0, "R8", "zero-config read strobe", s_rd_n_z, 0);
                    chk(m_rdata_z == s_rdata, "R8", "zero-config read data", m_rdata_z, s_rdata);
                end
            end
            if (!m_waitreq) begin
                fin = 1;
                chk(k == len - 1, do_w ? "R4" : "R6", "completion cycle", k, len - 1);
                if (!do_w) begin
                    rd_exp = s_rdata;
                    chk(m_rdata == s_rdata, "R7", "read data at completion", m_rdata, s_rdata);
                end
            end else if (k >= len + 2) begin
                fin = 1;
                chk(0, "R6", "waitrequest never dropped", k, len - 1);
            end
            @(negedge clk);
            s_rdata = $urandom;
            k++;
        end
        if (gap > 0) begin
            m_read = 0; m_write = 0;
            #1;
            chk(s_cs == 1'b0, do_w ? "R4" : "R5", "cs after sequence", s_cs, 0);
            chk(m_waitreq == 1'b0, "R6", "no wait when idle", m_waitreq, 0);
            if (!do_w)
                chk(m_rdata == rd_exp, "R7", "read data held", m_rdata, rd_exp);
            for (int i = 0; i < gap; i++) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "R6", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        // R1: reset with a request pending
        m_read = 1; m_be = 4'hA;
        repeat (3) @(negedge clk);
        #1;
        chk(!s_cs && !s_cs_z, "R1", "cs in reset", s_cs, 0);
        chk(s_rd_n && s_wr_n && s_rd_n_z, "R1", "strobes in reset", {s_rd_n, s_wr_n}, 2'b11);
        chk(s_be_n == 4'hF, "R1", "byte enables in reset", s_be_n, 4'hF);
        @(negedge clk);
        m_read = 0;
        rst_n = 1;
        repeat (2) @(negedge clk);
        // Directed corners
        xfer(0, 1, 16'h1234, 4'hF, 32'h0, 1);          // R5 R7 read
        xfer(1, 0, 16'h0042, 4'h3, 32'hCAFE_F00D, 1);  // R4 write with hold
        xfer(1, 1, 16'h00FF, 4'h1, 32'h1111_2222, 1);  // R10 both requested
        xfer(0, 1, 16'h2000, 4'h8, 32'h0, 0);          // R11 back-to-back
        xfer(1, 0, 16'h2004, 4'h6, 32'h3333_4444, 0);  // R11
        xfer(0, 1, 16'h2008, 4'hC, 32'h0, 2);
        // Constrained random traffic
        for (int n = 0; n < 60; n++) begin
            bit w = $urandom_range(0, 1);
            xfer(w, !w, 16'($urandom), 4'($urandom), $urandom, $urandom_range(0, 2));
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule